// File: doc/BRIEF.md
# I2C Target Address Comparator (Three Slots)

This block sits behind the bit-level receiver of an I2C target. It keeps three programmable address slots and decides whether the first byte that arrives after a START, or after a repeated START, selects this device. The receiver supplies that byte with a one-cycle valid strobe. The bus-condition detector supplies single-cycle START, repeated-START and STOP strobes. A host port writes the slots one byte at a time.

Each slot holds a 7-bit address in bits 7..1 and a direction bit in bit 0. In 7-bit mode only the address bits take part in the compare. In 10-bit mode all eight bits are compared. With the direction bit at 0, the slot matches the first byte of a write header. After a full two-byte header has been acknowledged, the host sets the direction bit to 1, so the header resent after a repeated START matches as a read. Every STOP returns all direction bits to 0.

The result is a registered match flag and slot index. They appear one cycle after the compared byte and stay put until the next bus condition.

Top module: `i2c_addr_match`

## Requirements
- R1: A host write with `cfg_we` high stores `cfg_wdata` into slot `cfg_sel` (0, 1 or 2) on the next clock edge. A write with `cfg_sel` equal to 3 changes no slot.
- R2: Only the first `rx_valid` byte after a START or repeated START is compared. Later bytes leave `match` and `match_idx` unchanged, and so does any byte that arrives after a STOP and before the next START.
- R3: When `mode_10b` is 0, bit 0 of the byte and bit 0 of the slot are ignored. A slot matches when bits 7..1 are equal.
- R4: When `mode_10b` is 1, a slot matches only when all 8 bits of the byte equal the slot.
- R5: When several slots match, `match_idx` reports the lowest-numbered one. `match` is 1 exactly when at least one slot matches.
- R6: A STOP strobe clears bit 0 of every slot on the next edge. Bits 7..1 are kept.
- R7: If a host write and a STOP fall in the same cycle, the written bits 7..1 are stored, but bit 0 ends as 0.
- R8: `match` and `match_idx` update on the edge after the compared byte and then hold. Any START, repeated START or STOP clears them to 0 on the next edge.
- R9: After reset, `match` is 0, `match_idx` is 0, every slot is 0x00 and no byte is armed for compare.
- R10: A repeated START arms the compare exactly as a START does. After the host sets a slot's bit 0 to 1, that slot matches in 10-bit mode a header byte that ends in 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Host slot write enable |
| cfg_sel | input | 2 | Slot number for the host write |
| cfg_wdata | input | 8 | Slot value: address in bits 7..1, direction in bit 0 |
| mode_10b | input | 1 | 1 selects 10-bit addressing compare rules |
| start_det | input | 1 | One-cycle START strobe |
| rstart_det | input | 1 | One-cycle repeated-START strobe |
| stop_det | input | 1 | One-cycle STOP strobe |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe marking `rx_byte` valid |
| match | output | 1 | A slot matched the compared byte |
| match_idx | output | 2 | Lowest matching slot number |

## Verification
The hardest case to reach from the ports is the 10-bit read path. It needs a header byte compared with bit 0 at 0, then a host write that sets bit 0, then a repeated START followed by the same header ending in 1. After that, a STOP has to be shown to undo the host's setting. The stimulus runs this whole sequence in order. It also lands a host write and a STOP in one cycle. Bit 0 has no read-back port, so its value is judged from the match outcome of the next 10-bit header.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int NREG = 3,
  parameter int AW = 8,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             mode_10b,
  input  logic             start_det,
  input  logic             rstart_det,
  input  logic             stop_det,
  input  logic [AW-1:0]    rx_byte,
  input  logic             rx_valid,
  output logic             match,
  output logic [IDX_W-1:0] match_idx
);

  logic [AW-1:0]    slot_q [NREG];
  logic [NREG-1:0]  hit;
  logic [NREG-1:0]  dir_bits;
  logic [IDX_W-1:0] hit_idx;
  logic             armed_q;

  wire arm_evt = start_det | rstart_det;
  wire bus_evt = arm_evt | stop_det;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[i] <= '0;
      else begin
        if (cfg_we && cfg_sel == IDX_W'(i)) slot_q[i] <= cfg_wdata;
        if (stop_det) slot_q[i][0] <= 1'b0;
      end
    end
    assign hit[i] = mode_10b ? (rx_byte == slot_q[i])
                             : (rx_byte[AW-1:1] == slot_q[i][AW-1:1]);
    assign dir_bits[i] = slot_q[i][0];
  end

  always_comb begin
    hit_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (hit[i]) hit_idx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      match     <= 1'b0;
      match_idx <= '0;
    end else if (bus_evt) begin
      armed_q   <= arm_evt;
      match     <= 1'b0;
      match_idx <= '0;
    end else if (rx_valid && armed_q) begin
      armed_q   <= 1'b0;
      match     <= |hit;
      match_idx <= hit_idx;
    end
  end

  a_r8_clear_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    bus_evt |=> (!match && match_idx == '0));

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_evt && !rx_valid) |=> ($stable(match) && $stable(match_idx)));

  a_r2_unarmed_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_evt && rx_valid && !armed_q) |=> ($stable(match) && $stable(match_idx)));

  a_r6_stop_clears_dir: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (dir_bits == '0));

  a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (int'(match_idx) < NREG));

  a_r2_single_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !bus_evt) |=> !armed_q);

endmodule

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, mode_10b = 0, start_det = 0, rstart_det = 0, stop_det = 0, rx_valid = 0;
  logic [1:0] cfg_sel = 0;
  logic [7:0] cfg_wdata = 0, rx_byte = 0;
  logic match;
  logic [1:0] match_idx;

  int checks = 0, failures = 0;
  logic [7:0] m_slot [3];
  bit m_armed = 0;
  logic m_match = 0;
  logic [1:0] m_idx = 0;
  logic [2:0] sb_q [$];
  string tag_q [$];
  logic v_d = 0;

  always #2.5 clk = ~clk;

  i2c_addr_match u_dut (.clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .mode_10b,
    .start_det, .rstart_det, .stop_det, .rx_byte, .rx_valid, .match, .match_idx);

  always @(posedge clk) v_d <= rx_valid;

  always @(negedge clk) if (v_d && sb_q.size() > 0) begin
    logic [2:0] e;
    string t;
    e = sb_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if ({match, match_idx} !== e) begin
      failures++;
      $display("FAIL %s: match/idx actual=%b/%0d expected=%b/%0d", t, match, match_idx, e[2], e[1:0]);
    end
  end

  task automatic check_now(string t);
    checks++;
    if ({match, match_idx} !== {m_match, m_idx}) begin
      failures++;
      $display("FAIL %s: match/idx actual=%b/%0d expected=%b/%0d", t, match, match_idx, m_match, m_idx);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d, input bit with_stop = 0);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d; stop_det = with_stop;
    @(negedge clk);
    cfg_we = 0; stop_det = 0;
    if (s < 3) m_slot[s] = d;
    if (with_stop) begin
      foreach (m_slot[i]) m_slot[i][0] = 1'b0;
      m_armed = 0; m_match = 0; m_idx = 0;
    end
  endtask

  task automatic cond(input int kind);
    if (kind == 0) start_det = 1; else if (kind == 1) rstart_det = 1; else stop_det = 1;
    @(negedge clk);
    start_det = 0; rstart_det = 0; stop_det = 0;
    m_match = 0; m_idx = 0; m_armed = (kind != 2);
    if (kind == 2) foreach (m_slot[i]) m_slot[i][0] = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input string t);
    if (m_armed) begin
      m_armed = 0; m_match = 0; m_idx = 0;
      for (int i = 2; i >= 0; i--) begin
        if (mode_10b ? (b == m_slot[i]) : (b[7:1] == m_slot[i][7:1])) begin
          m_match = 1; m_idx = 2'(i);
        end
      end
    end
    sb_q.push_back({m_match, m_idx});
    tag_q.push_back(t);
    rx_byte = b; rx_valid = 1;
    @(negedge clk);
    rx_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    foreach (m_slot[i]) m_slot[i] = 8'h00;
    repeat (3) @(negedge clk);
    check_now("R9 reset outputs");
    rst_n = 1;
    @(negedge clk);
    send(8'h00, "R9 no armed byte after reset");

    wr(0, 8'h30); wr(1, 8'hA0); wr(2, 8'hA0);
    cond(0); send(8'hA1, "R3 7-bit ignores bit0 / R5 lowest slot");
    send(8'h30, "R2 second byte not compared");
    repeat (3) @(negedge clk);
    check_now("R8 result holds while idle");
    cond(0); check_now("R8 START clears result");
    send(8'h31, "R3 slot0 7-bit");
    cond(0); send(8'h44, "R3 no slot matches");

    wr(3, 8'h44);
    cond(0); send(8'h44, "R1 cfg_sel=3 writes nothing");
    wr(2, 8'h66);
    cond(0); send(8'h67, "R1 slot2 written");

    mode_10b = 1;
    cond(0); send(8'hA1, "R4 10-bit bit0 must match");
    cond(0); send(8'hA0, "R4 10-bit full match slot1");
    cond(1); send(8'hA1, "R10 repeated START before bit0 set");
    wr(1, 8'hA1);
    cond(1); send(8'hA1, "R10 read header after host sets bit0");
    cond(2); check_now("R8 STOP clears result");
    send(8'hA1, "R2 byte after STOP not compared");
    cond(0); send(8'hA1, "R6 STOP cleared bit0");
    cond(0); send(8'hA0, "R6 address bits kept");

    wr(0, 8'h31, 1);
    check_now("R8 STOP with write clears result");
    cond(0); send(8'h31, "R7 STOP beats bit0 write");
    cond(0); send(8'h30, "R7 address bits of write kept");
    cond(1); check_now("R8 repeated START clears result");

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule